// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction fires. It takes two operands and a five-bit condition mask. It evaluates five relations between the operands at the same time: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. Each relation is gated by its own mask bit. If any gated relation holds, the block issues a one-cycle trap request together with an error code. The code identifies a program-class exception with the trap sub-code.

A mode input chooses the operand width. In word mode only the low 32 bits of each 64-bit operand take part in the comparison. In doubleword mode all 64 bits take part. The surrounding pipeline presents one evaluation per `valid_i` strobe. The result appears on the cycle after the strobe is sampled. Operand fetch and the exception entry sequence belong to other blocks.

Top module: `trap_cmp_unit`

## Requirements
- R1: With condition bit 4 (value 5'h10) set, a trap fires when operand A is less than operand B as two's-complement numbers.
- R2: With condition bit 3 (value 5'h08) set, a trap fires when A is greater than B as two's-complement numbers.
- R3: With condition bit 2 (value 5'h04) set, a trap fires when A equals B.
- R4: With condition bit 1 (value 5'h02) set, a trap fires when A is less than B as unsigned numbers. With condition bit 0 (value 5'h01) set, a trap fires when A is greater than B as unsigned numbers.
- R5: The trap decision is the OR of every relation whose condition bit is set. Relations whose bit is clear have no effect.
- R6: When `dword_i` is 0 (word mode), bits 63:32 of both operands are ignored. The low 32 bits are compared as 32-bit signed and unsigned values. When `dword_i` is 1, all 64 bits are compared.
- R7: A condition field of 5'h00 never traps. A condition field of 5'h1F always traps.
- R8: `trap_o` is registered. It rises in the cycle after a clock edge that samples `valid_i` high with a trapping condition. It lasts one cycle unless `valid_i` is high again. No trap follows an edge where `valid_i` is low.
- R9: While `trap_o` is 1, `trap_code_o` equals 8'h74: class nibble 4'h7 for a program exception, sub-code nibble 4'h4 for a trap. While `trap_o` is 0, `trap_code_o` is 8'h00.
- R10: After a clock edge with `rst_n` low, `trap_o` and `trap_code_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Evaluate the presented operands this cycle |
| dword_i | input | 1 | 1: compare all 64 bits; 0: compare low word only |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| cond_i | input | 5 | Trap condition mask |
| trap_o | output | 1 | Trap request pulse |
| trap_code_o | output | 8 | Error code accompanying the trap |

## Verification
The only internal state is the result register. A wrong relation, a missing gate or bad width narrowing therefore shows up as a wrong `trap_o` in the cycle after the strobe, with no delay to hide it.

A pulse that sticks would appear as `trap_o` still high one cycle later, while the next strobe is idle. A stale or wrong code would appear on `trap_code_o` in that same cycle.

The sweep covers all 32 condition masks against operand pairs at the sign and word boundaries, in both modes. It includes pairs whose upper halves differ while their low halves match.

// File: rtl/trap_cmp_pkg.sv
// Shared constants for the conditional trap compare unit.
// Assumes: the condition mask bit order below is fixed by the instruction encoding.
package trap_cmp_pkg;
    localparam int COND_W  = 5;
    localparam int BIT_SLT = 4;
    localparam int BIT_SGT = 3;
    localparam int BIT_EQ  = 2;
    localparam int BIT_ULT = 1;
    localparam int BIT_UGT = 0;

    localparam int CODE_W = 8;
    localparam logic [3:0] CLASS_PROGRAM = 4'h7;
    localparam logic [3:0] SUB_TRAP      = 4'h4;
    localparam logic [CODE_W-1:0] TRAP_CODE = {CLASS_PROGRAM, SUB_TRAP};

    typedef logic [COND_W-1:0] cond_t;
endpackage

// File: rtl/trap_opnd_fmt.sv
// Operand formatter: produces sign- and zero-extended views of both operands.
// In word mode only the low WORD_W bits survive; in full mode operands pass through.
// Assumes WORD_W <= DATA_W; when equal, the mode input has no effect.
module trap_opnd_fmt #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              full_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] a_sx_o,
    output logic [DATA_W-1:0] b_sx_o,
    output logic [DATA_W-1:0] a_zx_o,
    output logic [DATA_W-1:0] b_zx_o
);
    localparam int HI_W = DATA_W - WORD_W;

    generate
        if (HI_W > 0) begin : g_narrow
            // Choose between full-width operands and extended low words.
            always_comb begin
                if (full_i) begin
                    a_sx_o = a_i;
                    b_sx_o = b_i;
                    a_zx_o = a_i;
                    b_zx_o = b_i;
                end else begin
                    a_sx_o = {{HI_W{a_i[WORD_W-1]}}, a_i[WORD_W-1:0]};
                    b_sx_o = {{HI_W{b_i[WORD_W-1]}}, b_i[WORD_W-1:0]};
                    a_zx_o = {{HI_W{1'b0}}, a_i[WORD_W-1:0]};
                    b_zx_o = {{HI_W{1'b0}}, b_i[WORD_W-1:0]};
                end
            end
        end else begin : g_pass
            // Single width configuration: no narrowing exists.
            always_comb begin
                a_sx_o = a_i;
                b_sx_o = b_i;
                a_zx_o = a_i;
                b_zx_o = b_i;
            end
        end
    endgenerate
endmodule

// File: rtl/trap_relate.sv
// Relation generator: evaluates all five operand relations in parallel.
// Output bit order matches the condition mask bit order from the package.
// Assumes inputs are already narrowed and extended by the formatter.
module trap_relate
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_sx_i,
    input  logic [DATA_W-1:0] b_sx_i,
    input  logic [DATA_W-1:0] a_zx_i,
    input  logic [DATA_W-1:0] b_zx_i,
    output cond_t             rel_o
);
    // One comparator per relation, placed at its mask position.
    always_comb begin
        rel_o          = '0;
        rel_o[BIT_SLT] = $signed(a_sx_i) < $signed(b_sx_i);
        rel_o[BIT_SGT] = $signed(a_sx_i) > $signed(b_sx_i);
        rel_o[BIT_EQ]  = (a_zx_i == b_zx_i);
        rel_o[BIT_ULT] = (a_zx_i < b_zx_i);
        rel_o[BIT_UGT] = (a_zx_i > b_zx_i);
    end
endmodule

// File: rtl/trap_mask_reduce.sv
// Mask and reduce: gates each relation by its condition bit and ORs the result.
// Assumes rel_i and cond_i share the package bit order.
module trap_mask_reduce
    import trap_cmp_pkg::*;
(
    input  cond_t rel_i,
    input  cond_t cond_i,
    output logic  hit_o
);
    cond_t gated;

    genvar gi;
    generate
        for (gi = 0; gi < COND_W; gi++) begin : g_gate
            // Enable one relation when its mask bit is set.
            assign gated[gi] = rel_i[gi] & cond_i[gi];
        end
    endgenerate

    // Any enabled relation that holds requests a trap.
    assign hit_o = |gated;
endmodule

// File: rtl/trap_cmp_unit.sv
// Conditional trap compare unit (top).
// Formats operands for the selected width, evaluates five relations, masks them
// with the condition field, and registers a one-cycle trap request plus code.
// Assumes one evaluation per valid_i strobe; synchronous active-low reset.
module trap_cmp_unit
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              dword_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              trap_o,
    output logic [CODE_W-1:0] trap_code_o
);
    logic [DATA_W-1:0] a_sx, b_sx, a_zx, b_zx;
    cond_t             rel;
    logic              hit;

    trap_opnd_fmt #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_fmt (
        .full_i (dword_i),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .a_sx_o (a_sx),
        .b_sx_o (b_sx),
        .a_zx_o (a_zx),
        .b_zx_o (b_zx)
    );

    trap_relate #(.DATA_W(DATA_W)) u_rel (
        .a_sx_i (a_sx),
        .b_sx_i (b_sx),
        .a_zx_i (a_zx),
        .b_zx_i (b_zx),
        .rel_o  (rel)
    );

    trap_mask_reduce u_red (
        .rel_i  (rel),
        .cond_i (cond_i),
        .hit_o  (hit)
    );

    // Result register: pulse and code for exactly the strobed evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_o      <= 1'b0;
            trap_code_o <= '0;
        end else begin
            trap_o      <= valid_i & hit;
            trap_code_o <= (valid_i & hit) ? TRAP_CODE : '0;
        end
    end

    // Signed relations are mutually exclusive and complete (basis of R7).
    assert_signed_trichotomy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel[BIT_SLT], rel[BIT_SGT], rel[BIT_EQ]}) == 1)
        else $error("signed relations not exclusive");

    assert_empty_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_i == '0) |=> !trap_o)
        else $error("empty mask trapped");

    assert_full_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_i == '1) |=> trap_o)
        else $error("full mask did not trap");

    assert_idle_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !trap_o)
        else $error("trap without strobe");

    assert_code_on_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_code_o == TRAP_CODE))
        else $error("wrong code with trap");

    assert_code_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> (trap_code_o == '0))
        else $error("code without trap");

    assert_word_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dword_i && cond_i == 5'h04 &&
         opa_i[WORD_W-1:0] == opb_i[WORD_W-1:0]) |=> trap_o)
        else $error("word equality missed");
endmodule

// File: tb/tb_trap_cmp_unit.sv
// Exhaustive condition sweep against boundary operand pairs in both widths.
module tb_trap_cmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        dword_i = 1'b0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [4:0]  cond_i = '0;
    logic        trap_o;
    logic [7:0]  trap_code_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trap_cmp_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dword_i(dword_i),
        .opa_i(opa_i), .opb_i(opb_i), .cond_i(cond_i),
        .trap_o(trap_o), .trap_code_o(trap_code_o)
    );

    logic [63:0] pool [10] = '{
        64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 64'h0000_0000_7FFF_FFFF,
        64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0005,
        64'h0000_0000_0000_0005, 64'h1234_5678_FFFF_FFFF
    };

    // Expected decision from R1-R6 arithmetic, independent of the design.
    function automatic bit expect_trap(logic [63:0] a, logic [63:0] b,
                                       logic [4:0] c, bit dw);
        longint      sa, sb;
        logic [63:0] ua, ub;
        sa = dw ? longint'(a) : longint'(int'(a[31:0]));
        sb = dw ? longint'(b) : longint'(int'(b[31:0]));
        ua = dw ? a : {32'h0, a[31:0]};
        ub = dw ? b : {32'h0, b[31:0]};
        return (c[4] && sa < sb) || (c[3] && sa > sb) || (c[2] && ua == ub) ||
               (c[1] && ua < ub) || (c[0] && ua > ub);
    endfunction

    function automatic string tag_of(logic [4:0] c, bit dw);
        if (c == 5'h00 || c == 5'h1F) return "R7";
        if (!dw) return "R6";
        case (c)
            5'h10: return "R1";
            5'h08: return "R2";
            5'h04: return "R3";
            5'h02, 5'h01: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual trap/code=%h expected=%h (cond=%h dw=%0b a=%h b=%h)",
                     req, act, exp, cond_i, dword_i, opa_i, opb_i);
        end
    endtask

    initial begin
        // R10: reset state.
        repeat (3) @(negedge clk);
        check("R10", {trap_o, trap_code_o}, 9'h000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int dw = 0; dw < 2; dw++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    for (int c = 0; c < 32; c++) begin
                        bit e;
                        dword_i = dw[0];
                        opa_i = pool[i];
                        opb_i = pool[j];
                        cond_i = c[4:0];
                        valid_i = 1'b1;
                        e = expect_trap(pool[i], pool[j], c[4:0], dw[0]);
                        @(negedge clk);
                        // Trap and R9 code one cycle after the strobe.
                        check(tag_of(c[4:0], dw[0]), {trap_o, trap_code_o},
                              e ? 9'h174 : 9'h000);
                        // R8: idle strobe with a trapping mask must not trap.
                        valid_i = 1'b0;
                        cond_i = 5'h1F;
                        @(negedge clk);
                        check("R8", {trap_o, trap_code_o}, 9'h000);
                    end
                end
            end
        end
        // R10: reset clears a pending pulse.
        valid_i = 1'b1; cond_i = 5'h1F;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", {trap_o, trap_code_o}, 9'h000);
        valid_i = 1'b0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule